// File: doc/BRIEF.md
# Interrupt Enable and Flag Register with Port-Change Detect

This block is the byte-wide interrupt control and status register of a small microcontroller core. It holds two global gates and three enable/flag pairs. The global gates are a high-priority master enable and a low-priority peripheral enable. The three pairs serve a timer overflow, an external edge event and a change detector on the upper input-port pins. Software reads and writes the register as one byte. Hardware events set the flags whether or not anything is enabled, so software can also poll them.

The change detector compares the synchronised port pins against a snapshot that is taken whenever the port is read. The change flag is forced on every cycle while the pins and the snapshot differ, so a software clear only holds once a port read has refreshed the snapshot. Each of the three sources has a priority bit that routes its request to either the high-priority or the low-priority request output.

Top module: `irq_ctrl_reg`

## Requirements
- R1: A synchronous reset clears every register bit to 0, except bit 0 (change flag), which takes the parameter CHG_FLAG_RST (default 1). Both request outputs are 0 after reset.
- R2: A write strobe loads all 8 bits from the write data. The value is readable on the next cycle when no hardware event occurs. Bit map: 7 high/master enable, 6 low enable, 5 timer enable, 4 external enable, 3 change enable, 2 timer flag, 1 external flag, 0 change flag.
- R3: A timer event pulse sets bit 2 and an external event pulse sets bit 1 at the next clock edge, whatever the enable bits hold.
- R4: Hardware never clears a flag. A flag that is set stays set until software writes 0 to it.
- R5: If a software write of 0 to a flag and a hardware set of the same flag fall in the same cycle, the flag ends up 1.
- R6: The port pins pass through a two-stage synchroniser. A pin change that makes them differ from the snapshot sets bit 0 three clock edges after the change is applied.
- R7: While the synchronised pins differ from the snapshot, writing 0 to bit 0 has no lasting effect. The bit reads 1 again on the next cycle.
- R8: A port-read strobe copies the synchronised pins into the snapshot on that clock edge. After that, clearing bit 0 holds for as long as the pins stay unchanged.
- R9: While bit 7 is 0, both request outputs are 0.
- R10: The high-priority request is 1 exactly when bit 7 is 1 and some source has its flag, its enable and its priority bit all set to 1.
- R11: The low-priority request is 1 exactly when bits 7 and 6 are both 1 and some source has its flag and its enable set to 1 and its priority bit at 0. Priority bits: 2 timer, 1 external, 0 change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register contents |
| port_rd | input | 1 | Port read strobe, refreshes the snapshot |
| port_pins | input | N_PINS | Asynchronous upper port pins |
| tmr_ovf | input | 1 | Timer overflow event pulse |
| ext_evt | input | 1 | External interrupt event pulse |
| src_prio | input | 3 | Per-source priority, 1 = high (2 timer, 1 external, 0 change) |
| irq_hi | output | 1 | High-priority interrupt request |
| irq_lo | output | 1 | Low-priority interrupt request |

## Verification
Request routing is tried with every one of the 256 register values under each of the 8 priority patterns. This separates the master gate, the low-priority gate, each enable/flag pairing and the priority steering. Timer and external pulses are applied with all enables off, and one of them again together with a clearing write, to show that polling works and that the hardware set wins. Each port pin is toggled on its own after a port read. The flag is sampled one edge before and one edge at the expected set time, which pins down the synchroniser latency. A clear is attempted before and after a port read to show that the mismatch holds the flag on.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int unsigned NUM_SRC = 3;

    // source positions inside the enable, flag and priority fields
    localparam int unsigned SRC_TMR = 2;
    localparam int unsigned SRC_EXT = 1;
    localparam int unsigned SRC_CHG = 0;

    typedef struct packed {
        logic               gie_hi;
        logic               gie_lo;
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] fl;
    } ctl_t;

    function automatic logic [NUM_SRC-1:0] pending(input ctl_t c);
        return c.en & c.fl;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/irq_change_detect.sv
module irq_change_detect #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins_s,
    input  logic         relatch,
    output logic         mismatch
);
    logic [W-1:0] snap;

    always_ff @(posedge clk) begin
        if (rst)          snap <= '0;
        else if (relatch) snap <= pins_s;
    end

    assign mismatch = |(pins_s ^ snap);
endmodule

// File: rtl/irq_request_gen.sv
module irq_request_gen
    import irq_ctrl_pkg::*;
(
    input  ctl_t               ctl,
    input  logic [NUM_SRC-1:0] prio,
    output logic               irq_hi,
    output logic               irq_lo
);
    logic [NUM_SRC-1:0] act;

    always_comb begin
        act    = pending(ctl);
        irq_hi = ctl.gie_hi & |(act & prio);
        irq_lo = ctl.gie_hi & ctl.gie_lo & |(act & ~prio);
    end
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned N_PINS       = 4,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter logic        CHG_FLAG_RST = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               port_rd,
    input  logic [N_PINS-1:0]  port_pins,
    input  logic               tmr_ovf,
    input  logic               ext_evt,
    input  logic [NUM_SRC-1:0] src_prio,
    output logic               irq_hi,
    output logic               irq_lo
);
    localparam logic [7:0] RST_WORD = {7'b0, CHG_FLAG_RST};

    ctl_t               ctl_q, ctl_d;
    logic [N_PINS-1:0]  pins_s;
    logic               chg_mismatch;
    logic [NUM_SRC-1:0] hw_set;

    irq_pin_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (port_pins),
        .dout (pins_s)
    );

    irq_change_detect #(.W(N_PINS)) u_chg (
        .clk      (clk),
        .rst      (rst),
        .pins_s   (pins_s),
        .relatch  (port_rd),
        .mismatch (chg_mismatch)
    );

    always_comb begin
        hw_set          = '0;
        hw_set[SRC_TMR] = tmr_ovf;
        hw_set[SRC_EXT] = ext_evt;
        hw_set[SRC_CHG] = chg_mismatch;
        ctl_d = ctl_q;
        if (reg_wr) ctl_d = ctl_t'(reg_wdata);
        ctl_d.fl = ctl_d.fl | hw_set;   // hardware set dominates a clear
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= ctl_t'(RST_WORD);
        else     ctl_q <= ctl_d;
    end

    irq_request_gen u_req (
        .ctl    (ctl_q),
        .prio   (src_prio),
        .irq_hi (irq_hi),
        .irq_lo (irq_lo)
    );

    assign reg_rdata = ctl_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       tmr_ovf,
    input logic       ext_evt,
    input logic [2:0] src_prio,
    input logic       irq_hi,
    input logic       irq_lo
);
    AST_TMR_SETS: assert property (@(posedge clk) disable iff (rst)
        tmr_ovf |=> reg_rdata[2]);                                          // R3
    AST_EXT_SETS: assert property (@(posedge clk) disable iff (rst)
        ext_evt |=> reg_rdata[1]);                                          // R3
    AST_TMR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[2] && !reg_wr) |=> reg_rdata[2]);                        // R4
    AST_EXT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[1] && !reg_wr) |=> reg_rdata[1]);                        // R4
    AST_HW_WINS: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_wdata[2] && tmr_ovf) |=> reg_rdata[2]);            // R5
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> reg_rdata[7:3] == $past(reg_wdata[7:3]));                // R2
    AST_MASTER_GATE: assert property (@(posedge clk) disable iff (rst)
        !reg_rdata[7] |-> (!irq_hi && !irq_lo));                            // R9
    AST_HI_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq_hi |-> |(reg_rdata[5:3] & reg_rdata[2:0] & src_prio));          // R10
    AST_LO_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq_lo |-> (reg_rdata[6] && |(reg_rdata[5:3] & reg_rdata[2:0] & ~src_prio))); // R11
endmodule

bind irq_ctrl_reg irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tmr_ovf   (tmr_ovf),
    .ext_evt   (ext_evt),
    .src_prio  (src_prio),
    .irq_hi    (irq_hi),
    .irq_lo    (irq_lo)
);

// File: tb/irq_ctrl_reg_bench.sv
module irq_ctrl_reg_bench;
    localparam logic CHG_RST = 1'b1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       port_rd = 1'b0;
    logic [3:0] port_pins = '0;
    logic       tmr_ovf = 1'b0;
    logic       ext_evt = 1'b0;
    logic [2:0] src_prio = '0;
    logic       irq_hi, irq_lo;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_ctrl_reg #(.N_PINS(4), .SYNC_STAGES(2), .CHG_FLAG_RST(CHG_RST)) u_irq_ctrl_reg (
        .clk (clk), .rst (rst), .reg_wr (reg_wr), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .port_rd (port_rd), .port_pins (port_pins),
        .tmr_ovf (tmr_ovf), .ext_evt (ext_evt), .src_prio (src_prio),
        .irq_hi (irq_hi), .irq_lo (irq_lo)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic port_read();
        port_rd = 1'b1;
        @(negedge clk);
        port_rd = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        cyc(3);
        check("R1 reset value", reg_rdata, {7'b0, CHG_RST});
        check("R1 irq_hi", {7'b0, irq_hi}, 8'h00);
        check("R1 irq_lo", {7'b0, irq_lo}, 8'h00);
        rst = 1'b0;
        cyc(1);

        // R2 R9 R10 R11: every register value under every priority pattern
        for (int p = 0; p < 8; p++) begin
            src_prio = 3'(p);
            for (int v = 0; v < 256; v++) begin
                logic [7:0] b;
                logic [2:0] act;
                b = 8'(v);
                wr(b);
                act = b[5:3] & b[2:0];
                check("R2 readback", reg_rdata, b);
                check(b[7] ? "R10 irq_hi" : "R9 irq_hi gated", {7'b0, irq_hi},
                      {7'b0, b[7] & |(act & 3'(p))});
                check(b[7] ? "R11 irq_lo" : "R9 irq_lo gated", {7'b0, irq_lo},
                      {7'b0, b[7] & b[6] & |(act & ~3'(p))});
            end
        end
        src_prio = '0;

        // R3 R4: polling with everything disabled
        wr(8'h00);
        tmr_ovf = 1'b1; cyc(1); tmr_ovf = 1'b0;
        check("R3 timer flag", reg_rdata, 8'h04);
        cyc(5);
        check("R4 timer flag held", reg_rdata, 8'h04);
        ext_evt = 1'b1; cyc(1); ext_evt = 1'b0;
        check("R3 external flag", reg_rdata, 8'h06);
        cyc(4);
        check("R4 both flags held", reg_rdata, 8'h06);
        wr(8'h00);
        check("R4 software clear", reg_rdata, 8'h00);

        // R5: clear and set in the same cycle
        tmr_ovf = 1'b1; ext_evt = 1'b1; wr(8'h00); tmr_ovf = 1'b0; ext_evt = 1'b0;
        check("R5 hardware set wins", reg_rdata, 8'h06);
        wr(8'h00);

        // R6 R7 R8: each pin alone
        for (int i = 0; i < 4; i++) begin
            port_read();
            wr(8'h00);
            check("R8 clear after port read", reg_rdata, 8'h00);
            port_pins[i] = ~port_pins[i];
            cyc(2);
            check("R6 not yet set after two edges", {7'b0, reg_rdata[0]}, 8'h00);
            cyc(1);
            check("R6 change flag set", {7'b0, reg_rdata[0]}, 8'h01);
            wr(8'h00);
            check("R7 clear does not hold", {7'b0, reg_rdata[0]}, 8'h01);
            cyc(3);
            check("R7 still set", {7'b0, reg_rdata[0]}, 8'h01);
            port_read();
            wr(8'h00);
            check("R8 clear holds after read", {7'b0, reg_rdata[0]}, 8'h00);
            cyc(4);
            check("R8 stays clear", {7'b0, reg_rdata[0]}, 8'h00);
        end

        // R10 R11: change source steered both ways
        port_pins = 4'h0; cyc(3); port_read();
        wr(8'h89); src_prio = 3'b001; cyc(1);
        check("R10 change to high", {6'b0, irq_hi, irq_lo}, 8'h02);
        wr(8'hC9); src_prio = 3'b000; cyc(1);
        check("R11 change to low", {6'b0, irq_hi, irq_lo}, 8'h01);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule